// File: doc/BRIEF.md
# SPI Shift-Register Port Expander Sequencer

This block gives a host one extra 8-bit input port and one extra 8-bit output port. It drives two external shift registers over a single SPI link. The first is a parallel-in/serial-out register that feeds MISO. The second is a serial-in/parallel-out latch that listens on MOSI. Both share SCK and one strobe line, `ld`. The input register sees `ld` inverted, as an active-low parallel load. The output latch copies its shift stage to its pins when `ld` rises.

A request arrives on a valid/ready channel that carries the byte to drive onto the output port. The block accepts the request in a cycle where `req_valid` and `req_ready` are both high. It then runs one sequence:

1. A first high pulse on `ld` freezes the input lines into the input register.
2. Eight SCK pulses shift the output byte out on MOSI and the input byte in on MISO at the same time.
3. The block captures the received byte on `rx_data`.
4. A second `ld` pulse moves the new output byte onto the latch pins.
5. A one-cycle `done` pulse ends the sequence.

The request channel applies back-pressure by dropping `req_ready` for the whole sequence, so `req_valid` has no effect while the block is busy. The result side has no back-pressure. `done` is a single-cycle strobe, and `rx_data` holds its value until the next accepted request.

Top module: `spi_io_expander`

## Requirements
- R1: After reset, `sck`, `ld` and `done` are low, `req_ready` is high and `rx_data` is zero.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the cycle after acceptance until the sequence ends. `req_valid` and `req_data` have no effect while `req_ready` is low: the running sequence's output byte, captured byte and `ld` pulse count do not change.
- R3: `ld` rises on the edge that accepts a request and stays high for exactly `2*LD_SCK*HALF_DIV` clock cycles. `sck` is low for the whole time `ld` is high.
- R4: After the first `ld` pulse ends, exactly `DATA_W` SCK pulses follow. Each pulse has a period of `2*HALF_DIV` clock cycles and SCK idles low. MOSI carries `req_data` most significant bit first. MOSI changes only on SCK falling edges, so it is stable at every rising edge.
- R5: MISO is sampled on each SCK rising edge, first bit into bit 7. The captured `rx_data` equals the input lines as they were during the first `ld` pulse.
- R6: Changes on the input lines after the first `ld` pulse has ended do not change the captured byte.
- R7: The output latch pins keep the previous byte throughout the shift. The second `ld` pulse starts on the 8th SCK falling edge and lasts `2*LD_SCK*HALF_DIV` cycles, after which the pins show the new byte.
- R8: `done` is high for exactly one cycle, `(4*LD_SCK+2*DATA_W)*HALF_DIV+1` clock edges after the accepting edge (41 with defaults). `rx_data` is valid then and stays stable until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle; request is taken when both are high |
| req_data | input | DATA_W | Byte to drive onto the output port |
| done | output | 1 | One-cycle end-of-sequence strobe |
| rx_data | output | DATA_W | Captured input-port byte |
| sck | output | 1 | Shift clock, idle low |
| mosi | output | 1 | Serial data to the output latch |
| miso | input | 1 | Serial data from the input register |
| ld | output | 1 | Active-high strobe shared by both external registers |

## Verification
With default parameters, all timing counts from the accepting edge E:

| Event | Edge |
|---|---|
| `ld` rises | E |
| First `ld` pulse ends | E+4 |
| SCK rising edge k | E+2(2k+1) |
| Second `ld` pulse starts | E+36 |
| `done` rises | E+41 |

The driver checks `ld`, `sck` and `req_ready` on the falling clock edges right after E, E+3 and E+4. It also checks the output latch pins at E+20, in the middle of the shift. A monitor pops the expected output byte, input byte and acceptance cycle from a queue whenever `done` is high. It compares the captured byte, the latch pins, the SCK pulse count and the exact latency. One falling edge later it checks that `done` has dropped and `rx_data` has held its value.

// File: rtl/spi_xp_pkg.sv
package spi_xp_pkg;
  typedef enum logic [2:0] {
    XP_IDLE,
    XP_LOAD,
    XP_SHIFT,
    XP_STROBE,
    XP_FIN
  } xp_state_t;
endpackage

// File: rtl/spi_xp_tick.sv
// Divider producing one tick per SCK half period while the sequence runs.
module spi_xp_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run)       cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  // The counter is cleared when idle, so a tick never occurs outside a run.
  assert_tick_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/spi_xp_shreg.sv
// Full-duplex shifter: MSB drives MOSI, MISO bit held on rise, shifted in on fall.
module spi_xp_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              rise,
  input  logic              fall,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] next_val
);
  logic [DATA_W-1:0] sr;
  logic              held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      held <= 1'b0;
    end else begin
      if (load)      sr <= load_val;
      else if (fall) sr <= next_val;
      if (rise)      held <= miso;
    end
  end

  assign next_val = {sr[DATA_W-2:0], held};
  assign mosi     = sr[DATA_W-1];

  // MOSI may only move on a falling edge or a new load (R4).
  assert_mosi_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall && !load) |=> $stable(mosi));
endmodule

// File: rtl/spi_io_expander.sv
module spi_io_expander #(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 2,
  parameter int LD_SCK   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [DATA_W-1:0] req_data,
  output logic              done,
  output logic [DATA_W-1:0] rx_data,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              ld
);
  import spi_xp_pkg::*;

  localparam int LD_TICKS = 2 * LD_SCK;
  localparam int MAXP     = (LD_TICKS > DATA_W) ? LD_TICKS : DATA_W;
  localparam int PW       = (MAXP > 1) ? $clog2(MAXP) : 1;
  localparam int RW       = $clog2(DATA_W + 1);
  localparam logic [PW-1:0] LD_LAST  = PW'(LD_TICKS - 1);
  localparam logic [PW-1:0] BIT_LAST = PW'(DATA_W - 1);

  xp_state_t         state;
  logic [PW-1:0]     ph;
  logic              sck_q, ld_q, done_q;
  logic [DATA_W-1:0] rx_q;
  logic              accept, run, tick, rise, fall;
  logic [DATA_W-1:0] next_val;

  assign req_ready = (state == XP_IDLE);
  assign accept    = req_valid && req_ready;
  assign run       = (state == XP_LOAD) || (state == XP_SHIFT) || (state == XP_STROBE);
  assign rise      = (state == XP_SHIFT) && tick && !sck_q;
  assign fall      = (state == XP_SHIFT) && tick && sck_q;

  spi_xp_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  spi_xp_shreg #(.DATA_W(DATA_W)) u_shreg (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_val(req_data),
    .rise(rise), .fall(fall), .miso(miso), .mosi(mosi), .next_val(next_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= XP_IDLE;
      ph     <= '0;
      sck_q  <= 1'b0;
      ld_q   <= 1'b0;
      done_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        XP_IDLE: if (accept) begin
          state <= XP_LOAD;
          ld_q  <= 1'b1;
          ph    <= '0;
        end
        XP_LOAD: if (tick) begin
          if (ph == LD_LAST) begin
            ph    <= '0;
            ld_q  <= 1'b0;
            state <= XP_SHIFT;
          end else ph <= ph + 1'b1;
        end
        XP_SHIFT: if (tick) begin
          if (!sck_q) sck_q <= 1'b1;
          else begin
            sck_q <= 1'b0;
            if (ph == BIT_LAST) begin
              ph    <= '0;
              ld_q  <= 1'b1;
              rx_q  <= next_val;
              state <= XP_STROBE;
            end else ph <= ph + 1'b1;
          end
        end
        XP_STROBE: if (tick) begin
          if (ph == LD_LAST) begin
            ph    <= '0;
            ld_q  <= 1'b0;
            state <= XP_FIN;
          end else ph <= ph + 1'b1;
        end
        XP_FIN: begin
          done_q <= 1'b1;
          state  <= XP_IDLE;
        end
        default: state <= XP_IDLE;
      endcase
    end
  end

  assign sck     = sck_q;
  assign ld      = ld_q;
  assign done    = done_q;
  assign rx_data = rx_q;

  // Checker state: SCK rises per sequence and LD high-time.
  logic [RW-1:0] rise_cnt;
  logic [15:0]   ld_len;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt <= '0;
      ld_len   <= '0;
    end else begin
      if (accept)    rise_cnt <= '0;
      else if (rise) rise_cnt <= rise_cnt + 1'b1;
      if (ld_q)      ld_len <= ld_len + 1'b1;
      else           ld_len <= '0;
    end
  end

  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  assert_sck_low_in_ld_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld |-> !sck);
  assert_ld_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ld) |-> (ld_len == 16'(LD_TICKS * HALF_DIV)));
  assert_eight_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rise_cnt == RW'(DATA_W)));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_rx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> $stable(rx_data));
endmodule

// File: tb/spi_io_expander_test.sv
module spi_io_expander_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [7:0] req_data = '0;
  logic req_ready, done, sck, mosi, miso, ld;
  logic [7:0] rx_data;

  always #4 clk = ~clk;

  spi_io_expander uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_data(req_data), .done(done), .rx_data(rx_data), .sck(sck),
    .mosi(mosi), .miso(miso), .ld(ld)
  );

  // External register models.
  logic [7:0] in_port = '0;
  logic [7:0] piso = '0;
  logic [7:0] sipo = '0;
  logic [7:0] out_port = '0;
  logic sh_ld_n;
  assign sh_ld_n = ~ld;
  always @(posedge sck or negedge sh_ld_n)
    if (!sh_ld_n) piso <= in_port;
    else          piso <= {piso[6:0], 1'b0};
  assign miso = piso[7];
  always @(posedge sck) sipo <= {sipo[6:0], mosi};
  always @(posedge ld) out_port <= sipo;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int nrise = 0;
  localparam int LAT = (4 * 1 + 2 * 8) * 2 + 1;
  logic [7:0] q_out[$];
  logic [7:0] q_in[$];
  int q_acc[$];
  logic [7:0] prev_out = '0;

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge sck) nrise <= nrise + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Monitor: pop expectations on done.
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_out.size() == 0) chk(1'b0, "R8 unexpected done", 1, 0);
      else begin
        logic [7:0] eo, ei;
        int ea;
        eo = q_out.pop_front();
        ei = q_in.pop_front();
        ea = q_acc.pop_front();
        chk(rx_data == ei, "R5 captured byte", rx_data, ei);
        chk(out_port == eo, "R7 latch pins after strobe", out_port, eo);
        chk(cyc - ea == LAT, "R8 latency", cyc - ea, LAT);
        chk(nrise == 8, "R4 sck pulses", nrise, 8);
      end
    end
  end

  task automatic xfer(input logic [7:0] o, input logic [7:0] i,
                      input bit change_in, input bit poke);
    int acc;
    logic [7:0] hold;
    in_port = i;
    @(negedge clk);
    req_valid = 1'b1;
    req_data  = o;
    @(posedge clk);
    #1;
    acc = cyc;
    nrise = 0;
    q_out.push_back(o);
    q_in.push_back(i);
    q_acc.push_back(acc);
    @(negedge clk);
    req_valid = 1'b0;
    req_data  = '0;
    chk(ld == 1'b1, "R3 ld high after accept", ld, 1);
    chk(sck == 1'b0, "R3 sck low during ld", sck, 0);
    chk(req_ready == 1'b0, "R2 ready low while busy", req_ready, 0);
    repeat (3) @(negedge clk);
    chk(ld == 1'b1, "R3 ld still high at 4th cycle", ld, 1);
    @(negedge clk);
    chk(ld == 1'b0, "R3 ld low after one sck period", ld, 0);
    if (change_in) in_port = ~i;   // R6: must not reach the capture
    if (poke) begin                // R2: ignored request
      req_valid = 1'b1;
      req_data  = 8'h5A;
      repeat (4) @(negedge clk);
      req_valid = 1'b0;
      req_data  = '0;
    end
    while (cyc < acc + 20) @(negedge clk);
    chk(out_port == prev_out, "R7 latch pins hold during shift", out_port, prev_out);
    while (!done) @(negedge clk);
    hold = rx_data;
    @(negedge clk);
    chk(done == 1'b0, "R8 done single cycle", done, 0);
    chk(rx_data == hold, "R8 rx_data stable after done", rx_data, hold);
    prev_out = o;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(sck == 1'b0, "R1 sck idle", sck, 0);
    chk(ld == 1'b0, "R1 ld idle", ld, 0);
    chk(done == 1'b0, "R1 done idle", done, 0);
    chk(rx_data == 8'h00, "R1 rx_data zero", rx_data, 0);
    xfer(8'hA5, 8'h3C, 1'b0, 1'b0);
    xfer(8'hFF, 8'h00, 1'b1, 1'b0);
    xfer(8'h00, 8'hFF, 1'b0, 1'b1);
    xfer(8'h81, 8'h7E, 1'b1, 1'b1);
    repeat (5) @(negedge clk);
    chk(rx_data == 8'h7E, "R8 rx_data held while idle", rx_data, 8'h7E);
    chk(out_port == 8'h81, "R2 latch unchanged by ignored request", out_port, 8'h81);
    chk(q_out.size() == 0, "R8 all sequences completed", q_out.size(), 0);
    summary();
  end

  initial begin
    #160000;
    failures++;
    $display("FAIL watchdog R8 actual=%0d expected=done", cyc);
    summary();
  end
endmodule